// File: doc/BRIEF.md
# Filter Gate Open/Close Controller

This block owns the open/closed state of up to four transaction filter paths. Software writes one register whose low nibble holds a desired-open bit per filter. A second nibble in the same register reports the state each filter has actually reached. A per-filter input gives the number of transactions still in flight on that path. A change of state is only committed once that number is zero, so a path is never cut while it still owns traffic.

Each path has a gate-open output that permits new transactions. The gate stays shut while either the desired state or the reached state of that path is closed. A close request therefore blocks new work at once and lets the outstanding count drain to zero. Software treats a change as complete when the reported nibble matches the nibble it wrote. The number of populated paths is a build parameter from 1 to 4.

Top module: `filter_gate_ctrl`

## Requirements
- R1: After synchronous reset every desired-open bit, every reached-open bit and every gate-open output is 0, and the register reads as 0.
- R2: A write updates the desired-open field at register bits [3:0], bit i for filter i, and the new value reads back from the cycle after the write edge.
- R3: At a clock edge where a filter's desired and reached bits differ and its in-flight count is zero, the reached bit (register bits [19:16], bit 16+i for filter i) takes the desired value. It reads back from the cycle after that edge.
- R4: While a filter's in-flight count is nonzero, its reached bit keeps its value whatever the desired bit is.
- R5: A gate-open output is 1 only when both the desired and reached bits of that filter are 1. A write that clears the desired bit closes the gate on the same edge that stores the write.
- R6: A gate opens on the same edge at which its reached bit becomes 1 while its desired bit is 1.
- R7: For filter indices at or above the populated count, written desired bits are dropped. Their desired and reached bits read 0, and every register bit outside [3:0] and [19:16] reads 0.
- R8: Writing register bits [19:16] has no effect on the reached bits.
- R9: If a write and a drain-to-zero land on the same edge, the reached bit is compared with the desired value held before that edge, and the written value is followed on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data; only bits [NUM_FILT-1:0] are stored |
| rd_data | output | 32 | Register read value: desired bits [3:0], reached bits [19:16] |
| busy_cnt | input | NUM_FILT*CNT_W | Per-filter in-flight transaction counts, filter i at [i*CNT_W +: CNT_W] |
| gate_open | output | NUM_FILT | Per-filter permission for new transactions |

## Verification
A software write to the desired nibble and a filter draining its last transaction can hit the same clock edge. In that case the reached bit must follow the old request and not the new one. The bench provokes this on purpose, with a close request that drains on the very edge where the opposite request is written. It also sweeps every request pattern against staggered drain delays, so writes fall on drain edges across all filters. A cycle-level reference held in the bench judges every cycle. It compares both nibbles, the unused bits and the gate outputs.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
  localparam int MAX_FILT = 4;
  localparam int REG_W    = 32;
  localparam int REQ_LSB  = 0;
  localparam int STAT_LSB = 16;

  typedef struct packed {
    logic want;
    logic have;
  } gate_state_t;
endpackage

// File: rtl/fgate_slice.sv
module fgate_slice #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic             wr_bit,
  input  logic [CNT_W-1:0] busy,
  output logic             want_o,
  output logic             have_o,
  output logic             open_o
);
  import fgate_pkg::*;

  gate_state_t st_q, st_n;
  logic        open_q;
  logic        drained;

  assign drained = (busy == '0);

  always_comb begin
    st_n = st_q;
    // reached state follows the request held before this edge
    if (drained && (st_q.want != st_q.have)) st_n.have = st_q.want;
    if (wr_stb) st_n.want = wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      open_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      open_q <= st_n.want & st_n.have;
    end
  end

  assign want_o = st_q.want;
  assign have_o = st_q.have;
  assign open_o = open_q;

  // R4: reached bit frozen while transactions remain
  a_r4_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (!drained) |=> $stable(have_o));

  // R3: mismatch with empty path commits on the next edge
  a_r3_follow: assert property (@(posedge clk) disable iff (rst)
    (drained && (want_o != have_o)) |=> (have_o != $past(have_o)));

  // R5: gate never open unless both bits are set
  a_r5_gate_needs_both: assert property (@(posedge clk) disable iff (rst)
    open_o |-> (want_o && have_o));

  // R6: gate opens together with the reached bit
  a_r6_open_edge: assert property (@(posedge clk) disable iff (rst)
    ($rose(have_o) && want_o) |-> open_o);
endmodule

// File: rtl/fgate_readback.sv
module fgate_readback #(
  parameter int NUM_FILT = 4
) (
  input  logic [NUM_FILT-1:0]        want,
  input  logic [NUM_FILT-1:0]        have,
  output logic [fgate_pkg::REG_W-1:0] rd_data
);
  import fgate_pkg::*;

  always_comb begin
    rd_data = '0;
    rd_data[REQ_LSB  +: NUM_FILT] = want;
    rd_data[STAT_LSB +: NUM_FILT] = have;
  end
endmodule

// File: rtl/filter_gate_ctrl.sv
module filter_gate_ctrl #(
  parameter int NUM_FILT = 4,
  parameter int CNT_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [31:0]               wr_data,
  output logic [31:0]               rd_data,
  input  logic [NUM_FILT*CNT_W-1:0] busy_cnt,
  output logic [NUM_FILT-1:0]       gate_open
);
  import fgate_pkg::*;

  localparam int UNUSED_W = REG_W - NUM_FILT;

  logic [NUM_FILT-1:0] want_v, have_v;
  logic [UNUSED_W-1:0] unused_wr_bits;

  assign unused_wr_bits = wr_data[REG_W-1:NUM_FILT];

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
    fgate_slice #(.CNT_W(CNT_W)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .wr_stb (wr_en),
      .wr_bit (wr_data[REQ_LSB + i]),
      .busy   (busy_cnt[i*CNT_W +: CNT_W]),
      .want_o (want_v[i]),
      .have_o (have_v[i]),
      .open_o (gate_open[i])
    );
  end

  fgate_readback #(.NUM_FILT(NUM_FILT)) u_rb (
    .want    (want_v),
    .have    (have_v),
    .rd_data (rd_data)
  );

  // R7: nothing outside the populated field bits ever reads as 1
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~(((32'd1 << NUM_FILT) - 32'd1) << STAT_LSB)
             & ~(((32'd1 << NUM_FILT) - 32'd1) << REQ_LSB)) == 32'd0);
endmodule

// File: tb/sim_filter_gate_ctrl.sv
module sim_filter_gate_ctrl;
  localparam int NF = 3;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [31:0]   wr_data;
  logic [31:0]   rd_data;
  logic [NF*CW-1:0] busy_cnt;
  logic [NF-1:0] gate_open;
  logic [CW-1:0] c [NF];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < NF; i++) busy_cnt[i*CW +: CW] = c[i];

  filter_gate_ctrl #(.NUM_FILT(NF), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy_cnt(busy_cnt), .gate_open(gate_open));

  // reference state per requirements R1..R3, R9
  logic [NF-1:0] mwant, mhave;
  always @(posedge clk) begin
    if (rst) begin
      mwant <= '0;
      mhave <= '0;
    end else begin
      for (int i = 0; i < NF; i++)
        if (c[i] == 0 && mwant[i] != mhave[i]) mhave[i] <= mwant[i];
      if (wr_en) mwant <= wr_data[NF-1:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2", {28'd0, rd_data[3:0]},   {29'd0, mwant});
    chk("R3", {28'd0, rd_data[19:16]}, {29'd0, mhave});
    chk("R5", {29'd0, gate_open},      {29'd0, mwant & mhave});
    chk("R7", {rd_data[31:20], rd_data[19], rd_data[15:4], rd_data[3]}, 32'd0);
  endtask

  // advance one edge, then compare and leave inputs for the caller
  task automatic tick();
    @(posedge clk); #2;
    cmp_all();
    wr_en = 1'b0;
  endtask

  task automatic drain_tick();
    tick();
    for (int i = 0; i < NF; i++) if (c[i] != 0) c[i] = c[i] - 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    for (int i = 0; i < NF; i++) c[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", rd_data, 32'd0);
    chk("R1", {29'd0, gate_open}, 32'd0);
    rst = 1'b0;
    tick();

    // sweep: every pattern against staggered drain delays; status field
    // written with inverse to exercise R8, high nibble bit 3 for R7
    for (int pat = 0; pat < 16; pat++) begin
      for (int dly = 0; dly < 4; dly++) begin
        wr_en = 1'b1;
        wr_data = {12'hA5C, ~pat[3:0], 12'h3C3, pat[3:0]};
        for (int i = 0; i < NF; i++) c[i] = CW'((dly + i) % 4);
        for (int k = 0; k < 6; k++) drain_tick();
      end
    end

    // R8: status field write alone changes nothing
    wr_en = 1'b1; wr_data = 32'h0;
    for (int k = 0; k < 3; k++) tick();
    wr_en = 1'b1; wr_data = 32'h000F_0000;
    tick();
    chk("R8", {28'd0, rd_data[19:16]}, 32'd0);

    // R7: absent filter request dropped
    wr_en = 1'b1; wr_data = 32'h0000_0008;
    tick(); tick();
    chk("R7", rd_data, 32'd0);

    // R4: close pending while filter 0 has 5 in flight
    wr_en = 1'b1; wr_data = 32'h1;
    tick(); tick();
    chk("R6", {31'd0, gate_open[0]}, 32'd1);
    c[0] = 3'd5; wr_en = 1'b1; wr_data = 32'h0;
    tick();
    chk("R5", {31'd0, gate_open[0]}, 32'd0);
    tick(); tick(); tick();
    chk("R4", {31'd0, rd_data[16]}, 32'd1);
    c[0] = 3'd0;
    tick();
    chk("R3", {31'd0, rd_data[16]}, 32'd0);

    // R9: drain and opposite request on the same edge
    wr_en = 1'b1; wr_data = 32'h1;
    tick(); tick();
    c[0] = 3'd1; wr_en = 1'b1; wr_data = 32'h0;
    tick();
    c[0] = 3'd0; wr_en = 1'b1; wr_data = 32'h1;
    tick();
    chk("R9", {30'd0, rd_data[16], rd_data[0]}, 32'h1);
    chk("R9", {31'd0, gate_open[0]}, 32'd0);
    tick();
    chk("R9", {30'd0, rd_data[16], rd_data[0]}, 32'h3);
    chk("R6", {31'd0, gate_open[0]}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule